// File: doc/BRIEF.md
# Tower-Field GF(4096) Multiplier

This block multiplies two 12-bit elements of GF(2^12). The larger field is built as a quadratic extension over GF(2^6) rather than reduced by a single degree-12 polynomial. Each operand is cut into a high and a low 6-bit half. Three half-field products, plus one scaling of a half-field product by a fixed constant, combine into the 12-bit result.

A second mode computes the step function that a Reed-Solomon decoder uses to walk its code generator. In this mode, `op_a` is multiplied by the fixed element 0xE01, and a zero input returns the element 1. `op_b` has no effect in this mode.

By default the result is registered, which adds one cycle of latency, and a valid flag travels alongside it. A parameter makes the path purely combinational instead.

Top module: `gf12_tower_mul`

## Requirements
- R1: While `rst_n` is low, and after it is released with no request issued, `out_valid` is 0 and `product` is 0x000.
- R2: Half-field products use x^6+x+1. If both operands have bits 11:6 equal to zero, `product` is the GF(64) product of the low halves, with its upper six bits zero. For example, 0x020 times 0x002 gives 0x003.
- R3: In multiply mode (`mode`=0), bits 11:6 of `product` are g(ah^al, bh^bl) XOR g(al, bl). Bits 5:0 are g(g(ah, bh), 0x21) XOR g(al, bl). Here g is the GF(64) product, ah/al are bits 11:6 and 5:0 of `op_a`, and bh/bl are the same halves of `op_b`.
- R4: In generator mode (`mode`=1), an `op_a` of 0 yields `product` 0x001.
- R5: In generator mode with a nonzero `op_a`, `product` equals the R3 product of `op_a` and 0xE01, and `op_b` has no effect.
- R6: In multiply mode, any operand times 0x000 gives 0x000, and any operand times 0x001 returns that operand unchanged.
- R7: In multiply mode, swapping `op_a` and `op_b` leaves `product` unchanged.
- R8: With the output register enabled (default), `out_valid` is `in_valid` delayed by one cycle. `product` is loaded only on cycles when `in_valid` is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe for the operands on this cycle |
| mode | input | 1 | 0 = multiply `op_a` by `op_b`, 1 = generator step on `op_a` |
| op_a | input | 12 | First operand, or the generator-step input |
| op_b | input | 12 | Second operand; ignored in generator mode |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| product | output | 12 | Field product |

## Verification
Generator and multiply requests can issue in back-to-back cycles. The bench therefore alternates `mode` on consecutive valid cycles and places a zero-input generator request right after a full multiply. This shows that the 0-to-1 override and the constant operand do not leak into the neighbouring result. Every request pushes a value computed independently into a queue, and a monitor pops one entry per valid output and compares it, so a result shifted by one cycle or taken from the wrong mode is reported as a mismatch.

// File: rtl/gf12_pkg.sv
package gf12_pkg;
  typedef enum logic {
    MODE_MUL = 1'b0,
    MODE_GEN = 1'b1
  } mul_mode_e;

  localparam int unsigned DEF_HALF_W = 6;
  localparam logic [DEF_HALF_W-1:0] DEF_RED = 6'h03;   // x^6 = x + 1
  localparam logic [DEF_HALF_W-1:0] DEF_MU  = 6'h21;   // extension constant
  localparam logic [2*DEF_HALF_W-1:0] DEF_GEN_K = 12'hE01;
endpackage

// File: rtl/gf_half_mult.sv
module gf_half_mult #(
  parameter int unsigned HALF_W = 6,
  parameter logic [HALF_W-1:0] RED = 6'h03
) (
  input  logic [HALF_W-1:0] a,
  input  logic [HALF_W-1:0] b,
  output logic [HALF_W-1:0] p
);
  // Shift-and-add: walk bits of a, doubling b each step modulo the polynomial.
  function automatic logic [HALF_W-1:0] half_mul(input logic [HALF_W-1:0] x,
                                                 input logic [HALF_W-1:0] y);
    logic [HALF_W-1:0] acc;
    logic [HALF_W-1:0] yy;
    acc = '0;
    yy  = y;
    for (int i = 0; i < HALF_W; i++) begin
      if (x[i]) acc = acc ^ yy;
      if (yy[HALF_W-1]) yy = {yy[HALF_W-2:0], 1'b0} ^ RED;
      else              yy = {yy[HALF_W-2:0], 1'b0};
    end
    return acc;
  endfunction

  always_comb p = half_mul(a, b);
endmodule

// File: rtl/gf12_tower_core.sv
module gf12_tower_core #(
  parameter int unsigned HALF_W = 6,
  parameter logic [HALF_W-1:0] RED = 6'h03,
  parameter logic [HALF_W-1:0] MU  = 6'h21,
  localparam int unsigned W = 2 * HALF_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] p
);
  logic [HALF_W-1:0] a_hi, a_lo, b_hi, b_lo;
  logic [HALF_W-1:0] cross_prod, low_prod, high_prod, high_scaled;
  logic [HALF_W-1:0] res_hi, res_lo;

  assign a_hi = a[W-1:HALF_W];
  assign a_lo = a[HALF_W-1:0];
  assign b_hi = b[W-1:HALF_W];
  assign b_lo = b[HALF_W-1:0];

  gf_half_mult #(.HALF_W(HALF_W), .RED(RED)) u_cross (
    .a(a_hi ^ a_lo), .b(b_hi ^ b_lo), .p(cross_prod));
  gf_half_mult #(.HALF_W(HALF_W), .RED(RED)) u_low (
    .a(a_lo), .b(b_lo), .p(low_prod));
  gf_half_mult #(.HALF_W(HALF_W), .RED(RED)) u_high (
    .a(a_hi), .b(b_hi), .p(high_prod));
  gf_half_mult #(.HALF_W(HALF_W), .RED(RED)) u_scale (
    .a(high_prod), .b(MU), .p(high_scaled));

  assign res_hi = cross_prod ^ low_prod;
  assign res_lo = high_scaled ^ low_prod;
  assign p = {res_hi, res_lo};
endmodule

// File: rtl/gf12_tower_mul.sv
module gf12_tower_mul
  import gf12_pkg::*;
#(
  parameter int unsigned HALF_W = DEF_HALF_W,
  parameter logic [HALF_W-1:0] RED = DEF_RED,
  parameter logic [HALF_W-1:0] MU  = DEF_MU,
  parameter logic [2*HALF_W-1:0] GEN_K = DEF_GEN_K,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic                  mode,
  input  logic [2*HALF_W-1:0]   op_a,
  input  logic [2*HALF_W-1:0]   op_b,
  output logic                  out_valid,
  output logic [2*HALF_W-1:0]   product
);
  localparam int unsigned W = 2 * HALF_W;
  localparam logic [W-1:0] ONE = W'(1);

  logic         is_gen;
  logic         gen_zero;
  logic [W-1:0] core_b;
  logic [W-1:0] core_p;
  logic [W-1:0] next_p;

  assign is_gen   = (mul_mode_e'(mode) == MODE_GEN);
  assign gen_zero = is_gen && (op_a == '0);
  assign core_b   = is_gen ? GEN_K : op_b;

  gf12_tower_core #(.HALF_W(HALF_W), .RED(RED), .MU(MU)) u_core (
    .a(op_a), .b(core_b), .p(core_p));

  assign next_p = gen_zero ? ONE : core_p;

  generate
    if (REG_OUT) begin : g_reg
      logic         vld_q;
      logic [W-1:0] prod_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          vld_q  <= 1'b0;
          prod_q <= '0;
        end else begin
          vld_q <= in_valid;
          if (in_valid) prod_q <= next_p;
        end
      end
      assign out_valid = vld_q;
      assign product   = prod_q;

      a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
      a_r8_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
      a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(product));
      a_r4_gen_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_gen && op_a == '0) |=> product == ONE);
      a_r6_zero_absorbs: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_gen && (op_a == '0 || op_b == '0)) |=> product == '0);
      a_r6_unit: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_gen && op_b == ONE) |=> product == $past(op_a));
    end else begin : g_comb
      assign out_valid = in_valid;
      assign product   = next_p;

      a_r4_gen_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (is_gen && op_a == '0) |-> product == ONE);
      a_r6_zero_absorbs: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_gen && (op_a == '0 || op_b == '0)) |-> product == '0);
      a_r6_unit: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_gen && op_b == ONE) |-> product == op_a);
    end
  endgenerate

  // R2: low-half-only operands keep the high half of the product empty
  a_r2_low_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_gen && op_a[W-1:HALF_W] == '0 && op_b[W-1:HALF_W] == '0)
      |-> core_p[W-1:HALF_W] == '0);
endmodule

// File: tb/tb_gf12_tower_mul.sv
module tb_gf12_tower_mul;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        mode = 1'b0;
  logic [11:0] op_a = '0;
  logic [11:0] op_b = '0;
  logic        out_valid;
  logic [11:0] product;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  logic [11:0] exp_q[$];
  string       req_q[$];

  always #5 clk = ~clk;

  gf12_tower_mul dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .product(product));

  // Carry-less product then polynomial reduction by x^6+x+1.
  function automatic logic [5:0] ref64(input logic [5:0] x, input logic [5:0] y);
    logic [11:0] t;
    t = '0;
    for (int i = 0; i < 6; i++) if (y[i]) t = t ^ (12'(x) << i);
    for (int k = 10; k >= 6; k--) if (t[k]) t = t ^ (12'h043 << (k - 6));
    return t[5:0];
  endfunction

  function automatic logic [11:0] ref12(input logic [11:0] a, input logic [11:0] b);
    logic [5:0] lo, hi;
    lo = ref64(a[5:0], b[5:0]);
    hi = ref64(a[11:6] ^ a[5:0], b[11:6] ^ b[5:0]) ^ lo;
    return {hi, ref64(ref64(a[11:6], b[11:6]), 6'h21) ^ lo};
  endfunction

  function automatic logic [11:0] refgen(input logic [11:0] a);
    return (a == 12'h000) ? 12'h001 : ref12(a, 12'hE01);
  endfunction

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%03h expected=%03h", req, act, exp);
    end
  endtask

  task automatic drive(input logic m, input logic [11:0] a, input logic [11:0] b,
                       input logic [11:0] exp, input string req);
    @(negedge clk);
    in_valid = 1'b1;
    mode = m;
    op_a = a;
    op_b = b;
    exp_q.push_back(exp);
    req_q.push_back(req);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      op_a = $urandom;
      op_b = $urandom;
      mode = $urandom;
    end
  endtask

  // Monitor: one queue entry per valid output.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        if (exp_q.size() == 0) begin
          check("R8 (unexpected out_valid)", product, 12'hxxx);
        end else begin
          logic [11:0] e;
          string r;
          e = exp_q.pop_front();
          r = req_q.pop_front();
          check(r, product, e);
        end
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [11:0] ra, rb, held;
    repeat (3) @(negedge clk);
    check("R1 product in reset", product, 12'h000);
    check("R1 out_valid in reset", {11'h0, out_valid}, 12'h000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 product after reset", product, 12'h000);
    check("R1 out_valid after reset", {11'h0, out_valid}, 12'h000);

    // R2: known half-field product and reference cases
    drive(1'b0, 12'h020, 12'h002, 12'h003, "R2 x^5*x");
    drive(1'b0, 12'h03F, 12'h03F, {6'h0, ref64(6'h3F, 6'h3F)}, "R2 all-ones low");
    drive(1'b0, 12'h015, 12'h02A, {6'h0, ref64(6'h15, 6'h2A)}, "R2 mixed low");
    // R3: full composite products
    drive(1'b0, 12'hFFF, 12'hFFF, ref12(12'hFFF, 12'hFFF), "R3 all ones");
    drive(1'b0, 12'h040, 12'h040, ref12(12'h040, 12'h040), "R3 high unit squared");
    // R4/R5 interleaved with multiply on consecutive cycles
    drive(1'b1, 12'h000, 12'h5A5, 12'h001, "R4 gen zero");
    drive(1'b0, 12'h123, 12'h456, ref12(12'h123, 12'h456), "R3 after gen");
    drive(1'b1, 12'h001, 12'h777, 12'hE01, "R5 gen of one");
    drive(1'b1, 12'h000, 12'hFFF, 12'h001, "R4 gen zero again");
    drive(1'b0, 12'h000, 12'h001, 12'h000, "R6 zero times one");
    // R6 identities
    drive(1'b0, 12'hABC, 12'h000, 12'h000, "R6 times zero");
    drive(1'b0, 12'hABC, 12'h001, 12'hABC, "R6 times one");
    drive(1'b0, 12'h001, 12'h3D7, 12'h3D7, "R6 one times");
    idle(3);

    // R8: hold while idle, out_valid low
    held = product;
    check("R8 out_valid low when idle", {11'h0, out_valid}, 12'h000);
    idle(2);
    check("R8 product holds", product, held);

    // Random sweep, alternating modes, with commutativity (R7)
    for (int n = 0; n < 200; n++) begin
      ra = $urandom;
      rb = $urandom;
      if (n % 3 == 2) ra = 12'h000;
      drive(1'b0, ra, rb, ref12(ra, rb), "R3 random");
      drive(1'b0, rb, ra, ref12(ra, rb), "R7 swapped");
      drive(1'b1, ra, $urandom, refgen(ra), "R5 gen random (op_b ignored)");
      drive(1'b0, ra, 12'h001, ra, "R6 unit random");
      if (n % 17 == 0) idle(1);
    end
    idle(3);
    check("R8 all results delivered", 12'(exp_q.size()), 12'h000);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule